// File: doc/BRIEF.md
# Two-Level Return Address Stack

This block keeps return addresses for a small 4-bit controller core. Each entry is 12 bits wide, the width of the program counter. A pointer that counts downward selects the entry. A push steps the pointer down and then stores the entry at the new position. A pop returns the entry at the current position and then steps the pointer up. Subroutine calls, interrupt acceptance and an explicit save of the address register all use the push request. Returns, interrupt returns and an explicit restore into the address register all use the pop request.

The pointer takes three meaningful values: 2 (empty), 1 and 0. Only positions 0 and 1 have storage behind them, so two levels of nesting are usable. A read from position 2 or 3 returns all zeros and raises a flag. Going past either end raises its own flag. Software can read and write the pointer directly as a 4-bit field whose top two bits are always zero.

A table lookup runs as a short sequence through the same stack: push the return address, request a program-word fetch at the address-register value, then pop the return address back.

Top module: `ret_stack2`

## Requirements
- R1: After synchronous reset the pointer reads 2, `busy_o` and `fetch_req_o` are low, and every flag output is low.
- R2: An accepted push (`push_i`) steps the pointer down by one and stores `wdata_i` at the new pointer position, one clock after the request.
- R3: An accepted pop (`pop_i`) puts the entry at the current pointer on `rdata_o` with `rvalid_o` high for one cycle, one clock after the request. The pointer steps up by one in the same clock.
- R4: Two pushes followed by two pops return the two values in reverse order, and the pointer ends at 2.
- R5: A pop taken while the pointer is 2 or 3 returns 12'h000 on `rdata_o` and pulses `undef_o` together with `rvalid_o`.
- R6: A push at pointer 0 wraps the pointer to 3 and pulses `ovf_o` one clock later. A push at pointer 3 moves the pointer to 2 and stores nothing.
- R7: A pop at pointer 2 or 3 leaves the pointer at 2 and pulses `unf_o` one clock later.
- R8: If two or more of `push_i`, `pop_i`, `tbl_i` and `sp_wr_i` are high in the same idle cycle, the pointer and the storage do not change, and `conflict_o` pulses one clock later.
- R9: `sp_rdata_o` always equals {2'b00, pointer}. A lone `sp_wr_i` loads the pointer from `sp_wdata_i[1:0]` and ignores bits 3:2.
- R10: A lone `tbl_i` pushes `wdata_i`. In the next cycle `busy_o` and `fetch_req_o` are high and `fetch_addr_o` holds the `ar_i` value from the request. In the cycle after that, the pushed value appears on `rdata_o` with `rvalid_o` and `tbl_done_o`, and the pointer is back at its value from before the request.
- R11: Every request input is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request (call, interrupt accept, address-register save) |
| pop_i | input | 1 | Pop request (return, interrupt return, address-register restore) |
| tbl_i | input | 1 | Start a table-lookup sequence |
| sp_wr_i | input | 1 | Direct pointer write |
| wdata_i | input | 12 | Value to push, or return address for a table lookup |
| ar_i | input | 12 | Address-register value used as the fetch address |
| sp_wdata_i | input | 4 | Pointer write value |
| sp_rdata_o | output | 4 | Pointer read value |
| rdata_o | output | 12 | Popped entry |
| rvalid_o | output | 1 | `rdata_o` carries a new pop result |
| tbl_done_o | output | 1 | Table-lookup sequence finished |
| fetch_req_o | output | 1 | Program-word fetch request |
| fetch_addr_o | output | 12 | Program-word fetch address |
| busy_o | output | 1 | Table-lookup sequence in progress |
| undef_o | output | 1 | Pop read a position with no storage |
| ovf_o | output | 1 | Push wrapped past position 0 |
| unf_o | output | 1 | Pop saturated at position 2 |
| conflict_o | output | 1 | Simultaneous requests were rejected |

## Verification
The main function is tried with three patterns. A balanced push/push/pop/pop pattern separates correct LIFO order from FIFO order and from a write at the wrong slot. An unbalanced pattern with a third push and extra pops separates wrap from saturation and checks that the undefined filler is all zeros. Mixed patterns cover direct pointer writes (including ones with the upper bits set), a table lookup with a stray push during its busy cycle, and colliding requests. Together these show that the pointer and the storage stay untouched whenever an operation must be dropped.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_POP  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int DEPTH = 2,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_val,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] push_slot,
  output logic          ovf_ev,
  output logic          unf_ev
);
  localparam logic [PW-1:0] EMPTY = PW'(DEPTH);

  logic at_top;

  assign push_slot = ptr_q - 1'b1;
  assign at_top    = (ptr_q >= EMPTY);
  assign ovf_ev    = push_en && (ptr_q == '0);
  assign unf_ev    = pop_en && at_top;

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= EMPTY;
    else if (wr_en)   ptr_q <= wr_val;
    else if (push_en) ptr_q <= push_slot;
    else if (pop_en)  ptr_q <= at_top ? EMPTY : ptr_q + 1'b1;
  end

  a_r2_push_steps_down: assert property (@(posedge clk) disable iff (rst)
    push_en |=> ptr_q == PW'($past(ptr_q) - 1));
  a_r6_wrap_at_zero: assert property (@(posedge clk) disable iff (rst)
    (push_en && ptr_q == '0) |=> ptr_q == '1);
  a_r7_saturate_top: assert property (@(posedge clk) disable iff (rst)
    (pop_en && ptr_q >= EMPTY) |=> ptr_q == EMPTY);
  a_r8_single_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_en, pop_en, wr_en}));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DW    = 12,
  parameter int DEPTH = 2,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata_q,
  output logic          undef_q
);
  logic [DW-1:0] mem [DEPTH];
  logic          r_real;
  logic          w_real;

  assign r_real = (int'(raddr) < DEPTH);
  assign w_real = (int'(waddr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_en && w_real) mem[waddr] <= wdata;
    if (rd_en) rdata_q <= r_real ? mem[raddr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) undef_q <= 1'b0;
    else     undef_q <= rd_en && !r_real;
  end

  a_r5_filler_zero: assert property (@(posedge clk) disable iff (rst)
    undef_q |-> rdata_q == '0);
endmodule

// File: rtl/ras_seq.sv
module ras_seq
  import ras_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] ar,
  output logic          busy,
  output logic          seq_pop,
  output logic [AW-1:0] fetch_addr_q,
  output logic          done_q
);
  seq_state_t st_q;

  assign busy    = (st_q == SEQ_POP);
  assign seq_pop = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= busy;
      if (busy)       st_q <= SEQ_IDLE;
      else if (start) st_q <= SEQ_POP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 fetch_addr_q <= '0;
    else if (start && !busy) fetch_addr_q <= ar;
  end

  a_r10_one_busy_cycle: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy));
endmodule

// File: rtl/ret_stack2.sv
module ret_stack2 #(
  parameter int AW    = 12,
  parameter int DEPTH = 2,
  parameter int SPW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           tbl_i,
  input  logic           sp_wr_i,
  input  logic [AW-1:0]  wdata_i,
  input  logic [AW-1:0]  ar_i,
  input  logic [SPW-1:0] sp_wdata_i,
  output logic [SPW-1:0] sp_rdata_o,
  output logic [AW-1:0]  rdata_o,
  output logic           rvalid_o,
  output logic           tbl_done_o,
  output logic           fetch_req_o,
  output logic [AW-1:0]  fetch_addr_o,
  output logic           busy_o,
  output logic           undef_o,
  output logic           ovf_o,
  output logic           unf_o,
  output logic           conflict_o
);
  localparam int PW = $clog2(DEPTH + 1);

  logic [2:0]    req_cnt;
  logic          busy, seq_pop, accept, clash;
  logic          push_en, pop_en, wr_en, ovf_ev, unf_ev;
  logic [PW-1:0] ptr_q, push_slot;

  assign req_cnt = 3'(push_i) + 3'(pop_i) + 3'(tbl_i) + 3'(sp_wr_i);
  assign accept  = !busy && (req_cnt == 3'd1);
  assign clash   = !busy && (req_cnt > 3'd1);
  assign push_en = accept && (push_i || tbl_i);
  assign pop_en  = (accept && pop_i) || seq_pop;
  assign wr_en   = accept && sp_wr_i;

  ras_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
    .wr_en(wr_en), .wr_val(sp_wdata_i[PW-1:0]), .ptr_q(ptr_q),
    .push_slot(push_slot), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  ras_store #(.DW(AW), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .wr_en(push_en), .waddr(push_slot),
    .wdata(wdata_i), .rd_en(pop_en), .raddr(ptr_q),
    .rdata_q(rdata_o), .undef_q(undef_o)
  );

  ras_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(accept && tbl_i), .ar(ar_i),
    .busy(busy), .seq_pop(seq_pop), .fetch_addr_q(fetch_addr_o),
    .done_q(tbl_done_o)
  );

  assign busy_o      = busy;
  assign fetch_req_o = busy;
  assign sp_rdata_o  = {{(SPW-PW){1'b0}}, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o   <= 1'b0;
      ovf_o      <= 1'b0;
      unf_o      <= 1'b0;
      conflict_o <= 1'b0;
    end else begin
      rvalid_o   <= pop_en;
      ovf_o      <= ovf_ev;
      unf_o      <= unf_ev;
      conflict_o <= clash;
    end
  end

  a_r8_conflict_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    conflict_o |-> ptr_q == $past(ptr_q));
  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    busy |-> !push_en && !wr_en);
  a_r3_valid_follows_pop: assert property (@(posedge clk) disable iff (rst)
    (accept && pop_i) |=> rvalid_o);
  a_r1_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> (sp_rdata_o == SPW'(DEPTH) && !busy_o && !rvalid_o));
endmodule

// File: tb/ret_stack2_bench.sv
module ret_stack2_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 0, pop_i = 0, tbl_i = 0, sp_wr_i = 0;
  logic [11:0] wdata_i = '0, ar_i = '0;
  logic [3:0]  sp_wdata_i = '0;
  logic [3:0]  sp_rdata_o;
  logic [11:0] rdata_o, fetch_addr_o;
  logic        rvalid_o, tbl_done_o, fetch_req_o, busy_o;
  logic        undef_o, ovf_o, unf_o, conflict_o;

  int checks = 0;
  int errors = 0;

  int mptr = 2;
  int mmem [2] = '{0, 0};
  bit mbusy = 0;
  int e_rdata, e_faddr;
  bit e_rv, e_done, e_undef, e_ovf, e_unf, e_conf;

  always #(PERIOD/2) clk = ~clk;

  ret_stack2 u_ret_stack2 (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .tbl_i(tbl_i),
    .sp_wr_i(sp_wr_i), .wdata_i(wdata_i), .ar_i(ar_i),
    .sp_wdata_i(sp_wdata_i), .sp_rdata_o(sp_rdata_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .tbl_done_o(tbl_done_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .busy_o(busy_o), .undef_o(undef_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .conflict_o(conflict_o)
  );

  task automatic chk(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  task automatic model_pop();
    e_rv = 1;
    e_undef = (mptr >= 2);
    e_rdata = (mptr < 2) ? mmem[mptr] : 0;
    if (mptr >= 2) begin
      e_unf = 1;
      mptr = 2;
    end else mptr = mptr + 1;
  endtask

  task automatic step(input bit pu, input bit po, input bit tb, input bit sw,
                      input int d, input int a, input int sd, input string tag);
    int n;
    @(negedge clk);
    push_i = pu; pop_i = po; tbl_i = tb; sp_wr_i = sw;
    wdata_i = 12'(d); ar_i = 12'(a); sp_wdata_i = 4'(sd);
    @(posedge clk);
    e_rv = 0; e_done = 0; e_undef = 0; e_ovf = 0; e_unf = 0; e_conf = 0;
    if (mbusy) begin
      model_pop();
      e_done = 1;
      mbusy = 0;
    end else begin
      n = int'(pu) + int'(po) + int'(tb) + int'(sw);
      if (n > 1) e_conf = 1;
      else if (pu || tb) begin
        if (mptr == 0) e_ovf = 1;
        mptr = (mptr + 3) % 4;
        if (mptr < 2) mmem[mptr] = d;
        if (tb) begin
          mbusy = 1;
          e_faddr = a;
        end
      end else if (po) model_pop();
      else if (sw) mptr = sd % 4;
    end
    #(PERIOD/4);
    chk(tag, "sp_rdata", int'(sp_rdata_o), mptr);
    chk(tag, "rvalid", int'(rvalid_o), int'(e_rv));
    if (e_rv) chk(tag, "rdata", int'(rdata_o), e_rdata);
    chk(tag, "undef", int'(undef_o), int'(e_undef));
    chk(tag, "ovf", int'(ovf_o), int'(e_ovf));
    chk(tag, "unf", int'(unf_o), int'(e_unf));
    chk(tag, "conflict", int'(conflict_o), int'(e_conf));
    chk(tag, "busy", int'(busy_o), int'(mbusy));
    chk(tag, "fetch_req", int'(fetch_req_o), int'(mbusy));
    if (mbusy) chk(tag, "fetch_addr", int'(fetch_addr_o), e_faddr);
    chk(tag, "tbl_done", int'(tbl_done_o), int'(e_done));
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "sp_rdata", int'(sp_rdata_o), 2);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "flags", int'({rvalid_o, undef_o, ovf_o, unf_o, conflict_o, tbl_done_o}), 0);
    // R2 pushes, R4 reverse-order pops, R3 pop data
    step(1, 0, 0, 0, 'h1A5, 0, 0, "R2");
    step(1, 0, 0, 0, 'h2B6, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, 0, "R4");
    // R5 and R7: pop from empty position
    step(0, 1, 0, 0, 0, 0, 0, "R5");
    // R6: third push wraps
    step(1, 0, 0, 0, 'h311, 0, 0, "R6");
    step(1, 0, 0, 0, 'h322, 0, 0, "R6");
    step(1, 0, 0, 0, 'h333, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 'h344, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    // R8: colliding requests
    step(1, 1, 0, 0, 'h7FF, 0, 0, "R8");
    step(1, 0, 0, 1, 'h7FE, 0, 0, "R8");
    step(0, 1, 1, 0, 'h7FD, 'h123, 0, "R8");
    // R9: pointer write ignores upper bits
    step(0, 0, 0, 1, 0, 0, 'hD, "R9");
    step(0, 1, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, 'h8, "R9");
    step(0, 0, 0, 1, 0, 0, 'h2, "R9");
    // R10: table lookup, R11: push during busy is dropped
    step(1, 0, 0, 0, 'h0C3, 0, 0, "R10");
    step(0, 0, 1, 0, 'h456, 'hABC, 0, "R10");
    step(1, 0, 0, 1, 'hBAD, 0, 'h3, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 0, 0, 0, "R4");
    // R10 from empty stack
    step(0, 0, 1, 0, 'h9E1, 'h5A5, 0, "R10");
    step(0, 1, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule